// File: doc/BRIEF.md
# Periodic Supply Level Classifier

This block decides, at regular intervals, which kind of cell is powering the chip. It keeps an interval timer running from the low-frequency timekeeping clock. When an evaluation is due, it raises an enable strobe to the two supply comparators and holds it for a short settling window. On the last cycle of that window it latches the two comparator results into a two-bit battery mode code. The rest of the chip reads that code to choose how it drives its outputs.

The first evaluation after reset does not follow the regular schedule. It comes after a fixed short delay, so the mode is known soon after power-up. After that, evaluations repeat at the normal interval of one minute. Two test selections shorten the interval, to 125 ms and to 31.25 ms, so a production tester does not have to wait. Every cycle count is a parameter. The defaults assume a 32768 Hz clock.

Top module: `supply_mode_monitor`

## Requirements
- R1: While reset is asserted, and until the first evaluation completes, `mode` is 00 (silver-oxide) and `cmp_en` is 0. An asserted reset returns `mode` to 00 from any other value.
- R2: After reset is released, call the first rising clock edge cycle 1. `cmp_en` is first high in cycle FIRST_CYC. It is low in every earlier cycle.
- R3: Each enable window keeps `cmp_en` high for exactly SETTLE_CYC consecutive cycles. `mode` takes its new value on the clock edge that ends the window. The new value is decoded from the comparator inputs present in the last cycle of the window.
- R4: Mode decode works as follows:
  - `below_eol`=1 gives 10 (end-of-life), whatever `above_lit` is.
  - `above_lit`=1 with `below_eol`=0 gives 01 (lithium).
  - Both inputs at 0 give 00 (silver-oxide).
- R5: Between evaluations `mode` holds its value. Comparator inputs that change while `cmp_en` is low have no effect on it.
- R6: With `test_sel`=00, successive windows start NORM_CYC cycles apart. The default is one minute.
- R7: With `test_sel`=01, successive windows start T1_CYC cycles apart. The default is 125 ms.
- R8: With `test_sel`=10 or 11, successive windows start T2_CYC cycles apart. The default is 31.25 ms.
- R9: The interval is measured from the start of the previous window. Suppose `test_sel` switches to a shorter interval and the cycles already elapsed reach that interval minus one. Then a window starts on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_32k | input | 1 | Timekeeping clock, 32768 Hz by default |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_sel | input | 2 | Interval select: 00 normal, 01 fast test, 10/11 fastest test |
| above_lit | input | 1 | Comparator result: supply at or above the lithium threshold |
| below_eol | input | 1 | Comparator result: supply at or below the end-of-life threshold |
| cmp_en | output | 1 | Comparator enable strobe, high during the settling window |
| mode | output | 2 | Registered battery mode: 00 silver-oxide, 01 lithium, 10 end-of-life |

## Verification
The bench builds the block with FIRST_CYC=30, NORM_CYC=200, T1_CYC=50, T2_CYC=20 and SETTLE_CYC=3. With these values a one-minute schedule shrinks to a few hundred cycles, so all three interval selections can each be timed edge to edge within one run. The short windows also make it possible to place an input change exactly on the last settling cycle. They also allow an interval switch to land on a counter value already past the new limit, and a mid-run reset to be timed against the post-reset delay.

// File: rtl/smm_pkg.sv
package smm_pkg;

   typedef enum logic [1:0] {
      MODE_SILVER = 2'b00,
      MODE_LITH   = 2'b01,
      MODE_EOL    = 2'b10
   } batt_mode_e;

   localparam logic [1:0] TSEL_NORMAL = 2'b00;
   localparam logic [1:0] TSEL_FAST   = 2'b01;

   // end-of-life result dominates: a sagging supply must never read as lithium
   function automatic batt_mode_e decode_mode(input logic at_lit, input logic at_eol);
      if (at_eol)
         return MODE_EOL;
      else if (at_lit)
         return MODE_LITH;
      else
         return MODE_SILVER;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/smm_timer.sv
module smm_timer #(
   parameter int unsigned FIRST_CYC = 983,
   parameter int unsigned NORM_CYC  = 1966080,
   parameter int unsigned T1_CYC    = 4096,
   parameter int unsigned T2_CYC    = 1024,
   parameter int unsigned CNT_W     = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] tsel,
   output logic       tick
);
   import smm_pkg::*;

   localparam logic [CNT_W-1:0] FIRST_M1 = CNT_W'(FIRST_CYC - 1);
   localparam logic [CNT_W-1:0] NORM_M1  = CNT_W'(NORM_CYC - 1);
   localparam logic [CNT_W-1:0] T1_M1    = CNT_W'(T1_CYC - 1);
   localparam logic [CNT_W-1:0] T2_M1    = CNT_W'(T2_CYC - 1);

   logic [CNT_W-1:0] elapsed;
   logic             first_pend;
   logic [CNT_W-1:0] lim_m1;

   always_comb begin
      if (first_pend) begin
         lim_m1 = FIRST_M1;
      end else begin
         case (tsel)
            TSEL_NORMAL: lim_m1 = NORM_M1;
            TSEL_FAST:   lim_m1 = T1_M1;
            default:     lim_m1 = T2_M1;
         endcase
      end
   end

   // ">=" so a switch to a shorter interval never waits for a wrap
   assign tick = (elapsed >= lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed    <= '0;
         first_pend <= 1'b1;
      end else if (tick) begin
         elapsed    <= '0;
         first_pend <= 1'b0;
      end else begin
         elapsed    <= elapsed + 1'b1;
      end
   end

   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick repeated"); // R9

endmodule

// File: rtl/smm_settle.sv
module smm_settle #(
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic cmp_en,
   output logic sample
);

   generate
      if (SETTLE_CYC == 1) begin : g_single
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= tick;
         end
         assign cmp_en = en_q;
         assign sample = en_q;
      end else begin : g_count
         localparam int unsigned EW = $clog2(SETTLE_CYC + 1);
         logic [EW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (tick)
               left_q <= EW'(SETTLE_CYC);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign cmp_en = (left_q != '0);
         assign sample = (left_q == EW'(1));
      end
   endgenerate

   AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cmp_en) else $error("window did not open"); // R3
   AST_WIN_CLOSES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmp_en) |-> $past(sample)) else $error("window closed early"); // R3

endmodule

// File: rtl/smm_classifier.sv
module smm_classifier (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample,
   input  logic       at_lit,
   input  logic       at_eol,
   output logic [1:0] mode
);
   import smm_pkg::*;

   batt_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_SILVER;
      else if (sample)
         mode_q <= decode_mode(at_lit, at_eol);
   end

   assign mode = mode_q;

   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample) |-> $stable(mode)) else $error("mode moved outside sample"); // R5
   AST_EOL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && at_eol) |=> (mode == 2'b10)) else $error("eol not latched"); // R4

endmodule

// File: rtl/supply_mode_monitor.sv
module supply_mode_monitor #(
   parameter int unsigned FIRST_CYC  = 983,
   parameter int unsigned NORM_CYC   = 1966080,
   parameter int unsigned T1_CYC     = 4096,
   parameter int unsigned T2_CYC     = 1024,
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic       clk_32k,
   input  logic       rst_n,
   input  logic [1:0] test_sel,
   input  logic       above_lit,
   input  logic       below_eol,
   output logic       cmp_en,
   output logic [1:0] mode
);
   import smm_pkg::*;

   localparam int unsigned MAX_CYC = max2(max2(FIRST_CYC, NORM_CYC), max2(T1_CYC, T2_CYC));
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (FIRST_CYC < 2) begin : g_bad_first
         $error("FIRST_CYC must be at least 2");
      end
      if (SETTLE_CYC >= NORM_CYC || SETTLE_CYC >= T1_CYC || SETTLE_CYC >= T2_CYC) begin : g_bad_ivl
         $error("every interval must exceed SETTLE_CYC");
      end
   endgenerate

   logic tick;
   logic sample;

   smm_timer #(
      .FIRST_CYC (FIRST_CYC),
      .NORM_CYC  (NORM_CYC),
      .T1_CYC    (T1_CYC),
      .T2_CYC    (T2_CYC),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk   (clk_32k),
      .rst_n (rst_n),
      .tsel  (test_sel),
      .tick  (tick)
   );

   smm_settle #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_settle (
      .clk    (clk_32k),
      .rst_n  (rst_n),
      .tick   (tick),
      .cmp_en (cmp_en),
      .sample (sample)
   );

   smm_classifier u_class (
      .clk    (clk_32k),
      .rst_n  (rst_n),
      .sample (sample),
      .at_lit (above_lit),
      .at_eol (below_eol),
      .mode   (mode)
   );

   AST_MODE_AFTER_WINDOW: assert property (@(posedge clk_32k) disable iff (!rst_n)
      !$stable(mode) |-> $past(cmp_en)) else $error("mode changed without window"); // R3
   AST_MODE_LEGAL: assert property (@(posedge clk_32k) disable iff (!rst_n)
      $past(sample) |-> (mode != 2'b11)) else $error("illegal mode code"); // R4

endmodule

// File: tb/supply_mode_monitor_bench.sv
`timescale 1ns/1ps
module supply_mode_monitor_bench;

   localparam int unsigned FIRST  = 30;
   localparam int unsigned NORM   = 200;
   localparam int unsigned T1     = 50;
   localparam int unsigned T2     = 20;
   localparam int unsigned SETTLE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] test_sel = 2'b00;
   logic       above_lit = 1'b0;
   logic       below_eol = 1'b0;
   logic       cmp_en;
   logic [1:0] mode;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   supply_mode_monitor #(
      .FIRST_CYC  (FIRST),
      .NORM_CYC   (NORM),
      .T1_CYC     (T1),
      .T2_CYC     (T2),
      .SETTLE_CYC (SETTLE)
   ) u_supply_mode_monitor (
      .clk_32k   (clk),
      .rst_n     (rst_n),
      .test_sel  (test_sel),
      .above_lit (above_lit),
      .below_eol (below_eol),
      .cmp_en    (cmp_en),
      .mode      (mode)
   );

   // {test_sel, above_lit, below_eol, expected mode}
   localparam logic [5:0] VEC [8] = '{
      {2'b10, 1'b1, 1'b0, 2'b01},
      {2'b10, 1'b0, 1'b0, 2'b00},
      {2'b10, 1'b0, 1'b1, 2'b10},
      {2'b10, 1'b1, 1'b1, 2'b10},
      {2'b01, 1'b1, 1'b0, 2'b01},
      {2'b01, 1'b0, 1'b1, 2'b10},
      {2'b00, 1'b0, 1'b0, 2'b00},
      {2'b11, 1'b1, 1'b0, 2'b01}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rise();
      while (cmp_en !== 1'b0) @(negedge clk);
      while (cmp_en !== 1'b1) @(negedge clk);
   endtask

   task automatic wait_close();
      wait_rise();
      while (cmp_en !== 1'b0) @(negedge clk);
   endtask

   task automatic measure_gap(output int gap);
      wait_rise();
      gap = 0;
      do begin @(negedge clk); gap++; end while (cmp_en !== 1'b0);
      do begin @(negedge clk); gap++; end while (cmp_en !== 1'b1);
   endtask

   task automatic post_reset_timeline(input int exp_mode);
      for (int k = 1; k <= int'(FIRST + SETTLE); k++) begin
         @(negedge clk);
         if (k == int'(FIRST) - 1) chk("R2 enable low before first slot", cmp_en, 0);
         if (k == int'(FIRST))     chk("R2 enable high at first slot", cmp_en, 1);
         if (k == int'(FIRST + SETTLE) - 1) begin
            chk("R3 enable still high in last window cycle", cmp_en, 1);
            chk("R1 mode default until first evaluation", mode, 0);
         end
         if (k == int'(FIRST + SETTLE)) begin
            chk("R3 enable low after window", cmp_en, 0);
            chk("R2 mode after first evaluation", mode, exp_mode);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int gap;
      // R1: reset state
      nclk(3);
      chk("R1 mode in reset", mode, 0);
      chk("R1 enable in reset", cmp_en, 0);

      // R2: first evaluation after release, lithium supply
      above_lit = 1'b1;
      rst_n = 1'b1;
      post_reset_timeline(1);

      // R6/R7/R8: interval per test selection
      test_sel = 2'b00;
      measure_gap(gap);
      chk("R6 normal interval", gap, NORM);
      test_sel = 2'b01;
      measure_gap(gap);
      chk("R7 test1 interval", gap, T1);
      test_sel = 2'b10;
      measure_gap(gap);
      chk("R8 test2 interval (10)", gap, T2);
      test_sel = 2'b11;
      measure_gap(gap);
      chk("R8 test2 interval (11)", gap, T2);

      // R4/R5: table of supply patterns, with noise between windows
      wait_close();
      for (int i = 0; i < 8; i++) begin
         int prev;
         prev = mode;
         above_lit = ~VEC[i][3];
         below_eol = ~VEC[i][2];
         nclk(2);
         above_lit = VEC[i][3];
         below_eol = ~VEC[i][2];
         nclk(2);
         chk("R5 inputs ignored between windows", mode, prev);
         test_sel  = VEC[i][5:4];
         above_lit = VEC[i][3];
         below_eol = VEC[i][2];
         wait_close();
         chk("R4 decoded mode", mode, VEC[i][1:0]);
      end

      // R3: only last window cycle counts
      test_sel = 2'b10;
      above_lit = 1'b0;
      below_eol = 1'b1;
      wait_close();
      wait_rise();
      nclk(SETTLE - 1);
      chk("R3 still in window", cmp_en, 1);
      above_lit = 1'b1;
      below_eol = 1'b0;
      @(negedge clk);
      chk("R3 window length", cmp_en, 0);
      chk("R3 last-cycle inputs latched", mode, 1);

      // R9: switch to shorter interval after it has already elapsed
      test_sel = 2'b00;
      wait_close();
      nclk(100);
      chk("R9 no window yet in normal", cmp_en, 0);
      test_sel = 2'b10;
      @(negedge clk);
      chk("R9 immediate window after switch", cmp_en, 1);

      // R1/R2: reset mid-run clears a non-default mode
      wait_close();
      above_lit = 1'b0;
      below_eol = 1'b1;
      test_sel = 2'b00;
      chk("R1 precondition mode lithium", mode, 1);
      rst_n = 1'b0;
      nclk(2);
      chk("R1 mode cleared by reset", mode, 0);
      chk("R1 enable cleared by reset", cmp_en, 0);
      rst_n = 1'b1;
      post_reset_timeline(2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule